// File: doc/BRIEF.md
# Write-only I2C configuration register target

This block is an I2C target that only accepts write transfers and holds a bank of 26 byte-wide configuration registers at addresses 00h through 19h. A system clock at least 16 times faster than SCL samples SCL and SDA through two-flop synchronisers. Start and stop conditions are recovered from edges on the synchronised lines.

After a start, the target compares the first byte with its fixed 7-bit address 1110101 and a write direction bit. If they match, it acknowledges the byte. The next byte sets an internal register pointer. Every byte after that is written to the register the pointer selects, and the pointer then advances by one. Every accepted byte is acknowledged by pulling SDA low for the ninth clock.

The register contents are presented as one flat parallel vector for the logic that consumes them. Bits that no field uses always read as zero. An active-low asynchronous reset clears the whole bank.

Top module: `led_cfg_i2c_slave`

## Requirements
- R1: While rst_ni is low, every bit of regs_o is 0 and sda_oe_o is 0.
- R2: A transfer begins only at a start (SDA falling while SCL is high) and ends at a stop (SDA rising while SCL is high). Bytes clocked outside a transfer are not acknowledged and do not change regs_o.
- R3: An address byte of 0xEA (address 1110101 followed by direction bit 0) is acknowledged: sda_oe_o is 1 while SCL is high on the ninth clock.
- R4: An address byte with the direction bit set (0xEB), or with any other address, is not acknowledged. Later bytes in that transfer are neither acknowledged nor written.
- R5: The byte after the address byte sets the register pointer, and the byte after that is written to the register the pointer selects. Register n appears at regs_o[8n+7:8n], and both bytes are acknowledged.
- R6: Each further data byte in the same transfer is written to the next higher register address.
- R7: Data bytes aimed at addresses above 19h are acknowledged, but no register changes.
- R8: Only writable bits are stored; all other bits stay 0. The writable masks are: 00h FFh; 01h and 04h 9Fh; 02h, 03h, 05h, 06h and 0Ah 1Fh; 07h, 08h, 09h and 0Bh to 16h 3Fh; 17h E7h; 18h and 19h 8Fh.
- R9: sda_oe_o is 0 during data bits and is released within a few system clocks of the falling SCL edge that ends the ninth clock.
- R10: A repeated start in the middle of a transfer abandons that transfer and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| regs_o | output | 208 | Register n at bits [8n+7:8n] |

## Verification
The hardest case to reach is a byte that arrives while the target has withdrawn from the bus. This happens after a rejected address, or when bytes are clocked with no start at all. Nothing at the ports shows that the state machine is idle, apart from missing acknowledges and a register image that does not change. The bench therefore keeps clocking complete bytes, including a correct address and data, after a read-direction address, after a foreign address and after a stop. It checks each ninth clock for no acknowledge and compares the full register image on every clock. Repeated starts and bursts that run past 19h cover the pointer edge cases.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;
  localparam int unsigned CFG_NUM_REGS = 26;
  localparam int unsigned CFG_REG_W    = 8;
  localparam logic [6:0]  CFG_DEV_ADDR = 7'b1110101;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA
  } rx_state_e;

  // writable bits per register address; unused bits forced to zero
  function automatic logic [7:0] reg_mask(input int unsigned a);
    if (a == 0)                          return 8'hFF;
    else if (a inside {1, 4})            return 8'h9F;
    else if (a inside {2, 3, 5, 6, 10})  return 8'h1F;
    else if (a inside {[7:9], [11:22]})  return 8'h3F;
    else if (a == 23)                    return 8'hE7;
    else if (a inside {24, 25})          return 8'h8F;
    else                                 return 8'h00;
  endfunction
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  // idle bus is high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
      prev_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[LAST];
    end
  end

  assign lvl_o  = stg_q[LAST];
  assign rise_o = stg_q[LAST] & ~prev_q;
  assign fall_o = ~stg_q[LAST] & prev_q;
endmodule

// File: rtl/i2c_wr_rx.sv
module i2c_wr_rx
  import led_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = CFG_DEV_ADDR,
  parameter int unsigned PTR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};

  rx_state_e        state_q;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       shift_q;
  logic [PTR_W-1:0] ptr_q;
  logic             ack_wait_q;
  logic             in_ack_q;
  logic             oe_q;
  logic             wr_en_q;
  logic [PTR_W-1:0] wr_addr_q;
  logic [7:0]       wr_data_q;
  logic [7:0]       byte_w;

  assign byte_w = {shift_q, sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      ptr_q      <= '0;
      ack_wait_q <= 1'b0;
      in_ack_q   <= 1'b0;
      oe_q       <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        ack_wait_q <= 1'b0;
        in_ack_q   <= 1'b0;
        oe_q       <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        ack_wait_q <= 1'b0;
        in_ack_q   <= 1'b0;
        oe_q       <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise_i && !in_ack_q && !ack_wait_q) begin
          shift_q   <= byte_w[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            ack_wait_q <= 1'b1;
            case (state_q)
              ST_ADDR: begin
                if (byte_w == ADDR_WR) state_q <= ST_PTR;
                else begin
                  state_q    <= ST_IDLE;
                  ack_wait_q <= 1'b0;
                end
              end
              ST_PTR: begin
                ptr_q   <= PTR_W'(byte_w);
                state_q <= ST_DATA;
              end
              ST_DATA: begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= byte_w;
                ptr_q     <= ptr_q + 1'b1;
              end
              default: ;
            endcase
          end
        end else if (scl_fall_i) begin
          if (ack_wait_q) begin
            ack_wait_q <= 1'b0;
            in_ack_q   <= 1'b1;
            oe_q       <= 1'b1;
          end else if (in_ack_q) begin
            in_ack_q <= 1'b0;
            oe_q     <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import led_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = CFG_NUM_REGS,
  parameter int unsigned PTR_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [PTR_W-1:0]      wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] MASK = reg_mask(g);
    logic [7:0] val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   val_q <= '0;
      else if (wr_en_i && wr_addr_i == PTR_W'(g))    val_q <= wr_data_i & MASK;
    end

    assign regs_o[g*8 +: 8] = val_q;
  end
endmodule

// File: rtl/led_cfg_i2c_slave.sv
module led_cfg_i2c_slave
  import led_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = CFG_DEV_ADDR,
  parameter int unsigned NUM_REGS = CFG_NUM_REGS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned PTR_W = 8;

  logic [1:0] lvl, rise, fall;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [7:0] wr_data;

  i2c_in_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = rise[0];
  assign scl_fall = fall[0];
  assign sda_rise = rise[1];
  assign sda_fall = fall[1];

  assign start_det = scl_lvl & ~scl_rise & sda_fall;
  assign stop_det  = scl_lvl & ~scl_rise & sda_rise;

  i2c_wr_rx #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_lvl),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/led_cfg_i2c_slave_chk.sv
module led_cfg_i2c_slave_chk #(
  parameter int unsigned NUM_REGS = 26
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_hi_i,
  input logic                  scl_fall_i,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  wr_en_i,
  input logic                  sda_oe_i,
  input logic [NUM_REGS*8-1:0] regs_i
);
  assert_ack_on_scl_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> $past(scl_fall_i));

  assert_ack_steady_scl_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hi_i && $past(scl_hi_i)) |-> $stable(sda_oe_i));

  assert_release_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_i) |-> $past(scl_fall_i || start_i || stop_i));

  assert_regs_only_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(regs_i));

  assert_start_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);
endmodule

bind led_cfg_i2c_slave led_cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_hi_i   (scl_lvl),
  .scl_fall_i (scl_fall),
  .start_i    (start_det),
  .stop_i     (stop_det),
  .wr_en_i    (wr_en),
  .sda_oe_i   (sda_oe_o),
  .regs_i     (regs_o)
);

// File: tb/led_cfg_i2c_slave_bench.sv
module led_cfg_i2c_slave_bench;
  localparam int NREG = 26;
  localparam int H    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic [NREG*8-1:0] exp_flat;
  logic [7:0] exp_q [NREG];
  bit win = 1'b1;
  bit done = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  led_cfg_i2c_slave u_led_cfg_i2c_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  // masks as listed in R8
  function automatic logic [7:0] wmask(input int a);
    case (a)
      0: return 8'hFF;
      1, 4: return 8'h9F;
      2, 3, 5, 6, 10: return 8'h1F;
      23: return 8'hE7;
      24, 25: return 8'h8F;
      default: return (a >= 7 && a <= 22) ? 8'h3F : 8'h00;
    endcase
  endfunction

  always_comb
    for (int i = 0; i < NREG; i++) exp_flat[i*8 +: 8] = exp_q[i];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference register image compared on every clock (R5, R6, R7, R8, R2, R4)
  always @(negedge clk)
    if (rst_n && !win && !done)
      chk(regs === exp_flat, "R5", "register image", regs, exp_flat);

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit do_wr,
                           input int waddr, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      wt(H);
      if (i == 0) win = 1'b1;
      scl_m = 1'b1;
      wt(H/2);
      if (i == 3) chk(sda_oe == 1'b0, "R9", "oe during data bit", sda_oe, 0);
      wt(H/2);
      scl_m = 1'b0;
    end
    if (do_wr && waddr < NREG) exp_q[waddr] = b & wmask(waddr);
    win = 1'b0;
    sda_m = 1'b1;
    wt(H);
    scl_m = 1'b1;
    wt(H/2);
    chk(sda_oe == exp_ack, req, "ack on ninth clock", sda_oe, exp_ack);
    wt(H/2);
    scl_m = 1'b0;
    wt(6);
    chk(sda_oe == 1'b0, "R9", "release after ninth clock", sda_oe, 0);
    wt(H-6);
  endtask

  task automatic do_reset();
    win = 1'b1;
    rst_n = 1'b0;
    wt(3);
    chk(regs == '0, "R1", "regs in reset", regs, '0);
    chk(sda_oe == 1'b0, "R1", "oe in reset", sda_oe, 0);
    for (int i = 0; i < NREG; i++) exp_q[i] = 8'h00;
    rst_n = 1'b1;
    wt(2);
    win = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_q[i] = 8'h00;
    wt(4);
    do_reset();
    wt(10);

    // R3 R5: single write
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h00, 1, 0, 0, "R5");
    send_byte(8'hA5, 1, 1, 0, "R5");
    bus_stop();

    // R6 R8: burst with masks
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h01, 1, 0, 0, "R5");
    for (int k = 0; k < 10; k++) send_byte(8'hFF, 1, 1, 1 + k, "R6");
    bus_stop();

    // R8: mask of 17h, overwrite 00h
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h17, 1, 0, 0, "R5");
    send_byte(8'hFF, 1, 1, 23, "R8");
    bus_stop();
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h00, 1, 0, 0, "R5");
    send_byte(8'h3C, 1, 1, 0, "R8");
    bus_stop();

    // R7: burst runs past 19h
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h18, 1, 0, 0, "R5");
    send_byte(8'hFF, 1, 1, 24, "R7");
    send_byte(8'hFF, 1, 1, 25, "R7");
    send_byte(8'hFF, 1, 1, 26, "R7");
    send_byte(8'h55, 1, 1, 27, "R7");
    bus_stop();
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h40, 1, 0, 0, "R7");
    send_byte(8'h77, 1, 1, 64, "R7");
    bus_stop();

    // R4: read direction, then foreign address
    bus_start();
    send_byte(8'hEB, 0, 0, 0, "R4");
    send_byte(8'h00, 0, 0, 0, "R4");
    send_byte(8'h11, 0, 0, 0, "R4");
    bus_stop();
    bus_start();
    send_byte(8'hEC, 0, 0, 0, "R4");
    send_byte(8'hEA, 0, 0, 0, "R4");
    send_byte(8'h02, 0, 0, 0, "R4");
    bus_stop();

    // R2: bytes with no start after a stop
    send_byte(8'hEA, 0, 0, 0, "R2");
    send_byte(8'h03, 0, 0, 0, "R2");
    send_byte(8'h0E, 0, 0, 0, "R2");
    wt(H);
    scl_m = 1'b1;
    wt(H);

    // R10: repeated start
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R3");
    send_byte(8'h05, 1, 0, 0, "R5");
    send_byte(8'h11, 1, 1, 5, "R10");
    bus_start();
    send_byte(8'hEA, 1, 0, 0, "R10");
    send_byte(8'h0A, 1, 0, 0, "R10");
    send_byte(8'h22, 1, 1, 10, "R10");
    send_byte(8'h2B, 1, 1, 11, "R10");
    bus_stop();

    // R1: reset with contents present
    wt(10);
    do_reset();
    wt(20);
    chk(regs == '0, "R1", "regs after reset", regs, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule